// File: doc/BRIEF.md
# Bit-Serial Real-Time Clock Slave

This block is a clock and battery-RAM device that software reaches by toggling three bits of a byte-wide control register. Bit 0 of the byte is a chip select and bit 1 is a serial clock. Bit 2 is a bidirectional data line. Every write from the CPU replaces the stored byte. When a write drops the clock bit from 1 to 0 while select is high, the device takes one bit. The first eight such edges build a command and the next eight build a value. Both are taken most significant bit first.

During the value half of a read command, the device puts the reply bit into bit 2 of the stored byte. Software therefore sees the reply bit on its next read of the control register. Write commands take effect once the sixteenth bit is in. Lowering select at any time cancels the access.

The device holds a small RAM, a status byte and a control byte. It also holds six BCD time-of-day fields that advance on a one-second tick input. One command clears two status flags. The same command also emits a one-cycle pulse that the system uses to clear the matching interrupt-status bit.

Top module: `serial_rtc`

## Requirements
- R1: After reset, ctl_rdata is 0x00 and irq_clr is low. All RAM bytes are 0x00, status is 0x90, and the time is 00:00:00 on day 01, month 01, year 00.
- R2: A CPU write stores ctl_wdata. ctl_rdata returns the stored byte one cycle later, and bits 7:3, 1 and 0 are always exactly as written.
- R3: A bit is taken only when a write has bit 0 high and lowers bit 1 from 1 to 0. Writes that keep bit 1 low, raise it, or hold it high shift nothing.
- R4: For commands 0x00 to 0x1F, each of the eight value-phase edges puts the next bit of the addressed RAM byte into ctl_rdata bit 2, most significant bit first.
- R5: For commands 0x80 to 0x9F, the sixteenth edge writes the value into RAM at address (command minus 0x80).
- R6: Command 0x30 returns the status byte and command 0x31 returns the control byte (0x00 by default). Both are returned on bit 2 in the same way as in R4.
- R7: The time commands return BCD fields: 0x20 gives seconds, 0x21 minutes, 0x22 hours, 0x24 day, 0x25 month and 0x26 the two-digit year. Every other command in 0x20 to 0x2F returns 0x00.
- R8: If command 0xB1 completes with value bit 2 set, status bits 4 and 3 are cleared and irq_clr is high for exactly one cycle. If value bit 2 is clear, nothing changes.
- R9: A write with bit 0 low cancels the access. The bit count returns to zero, the command and value clear, and a partially shifted write command stores nothing.
- R10: Each sec_tick cycle advances the time by one second. Seconds and minutes wrap from 59, hours wrap from 23, days wrap from 31 to 01, months wrap from 12 to 01, and years wrap from 99. Each wrap carries into the next field.
- R11: Commands outside the read ranges never drive bit 2. The byte read back then keeps the data bit that software wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | CPU write strobe for the control byte |
| ctl_wdata | input | 8 | Byte written: bit 0 select, bit 1 serial clock, bit 2 data |
| ctl_rdata | output | 8 | Stored control byte, with bit 2 driven by the device during replies |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| irq_clr | output | 1 | One-cycle pulse requesting that interrupt-status bit 2 be cleared |

## Verification
The bench sweeps every RAM address with an arithmetic byte pattern, first writing it and then reading it back. This checks both the address decode and the bit order. A second transfer has an extra write after each edge, with the clock bit low and the data bit inverted; this tells edge-only shifting apart from level sampling. The bench also cancels a write after ten bits and confirms that no RAM byte changes. It reads all sixteen time codes after counted tick bursts, one of which crosses midnight, and compares them with BCD values worked out from the tick count. It runs the status-clear command twice, once with value bit 2 clear and once with it set. Finally, it sends a non-read command, and the byte it drove must come back unchanged.

// File: rtl/serial_rtc.sv
module serial_rtc #(
  parameter int          RAM_DEPTH    = 32,
  parameter logic [7:0]  STATUS_INIT  = 8'h90,
  parameter logic [7:0]  CONTROL_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       sec_tick,
  output logic       irq_clr
);
  localparam int AW = $clog2(RAM_DEPTH);
  localparam logic [7:0] WR_BASE = 8'h80;
  localparam logic [7:0] WR_LAST = 8'h80 + 8'(RAM_DEPTH - 1);
  localparam logic [7:0] RD_LAST = 8'(RAM_DEPTH - 1);

  logic [7:0] ctl_q, cmd_q, val_q, status_q;
  logic [4:0] phase_q;
  logic [7:0] ram [RAM_DEPTH];
  logic [7:0] sec_q, min_q, hr_q, day_q, mon_q, yr_q;
  logic       irq_q;

  wire fall     = ctl_we && ctl_wdata[0] && ctl_q[1] && !ctl_wdata[1];
  wire abort    = ctl_we && !ctl_wdata[0];
  wire in_cmd   = fall && (phase_q < 5'd8);
  wire in_val   = fall && (phase_q >= 5'd8) && (phase_q < 5'd16);
  wire last_bit = fall && (phase_q == 5'd15);
  wire [7:0] val_nx = {val_q[6:0], ctl_wdata[2]};
  wire [2:0] bit_idx = 3'd7 - phase_q[2:0];

  logic       reply_hit;
  logic [7:0] reply_byte;
  always_comb begin
    reply_hit  = 1'b1;
    reply_byte = 8'h00;
    if (cmd_q <= RD_LAST) reply_byte = ram[cmd_q[AW-1:0]];
    else if (cmd_q[7:4] == 4'h2) begin
      case (cmd_q[3:0])
        4'h0:    reply_byte = sec_q;
        4'h1:    reply_byte = min_q;
        4'h2:    reply_byte = hr_q;
        4'h4:    reply_byte = day_q;
        4'h5:    reply_byte = mon_q;
        4'h6:    reply_byte = yr_q;
        default: reply_byte = 8'h00;
      endcase
    end
    else if (cmd_q == 8'h30) reply_byte = status_q;
    else if (cmd_q == 8'h31) reply_byte = CONTROL_INIT;
    else reply_hit = 1'b0;
  end

  wire drive    = in_val && reply_hit;
  wire do_wr    = last_bit && (cmd_q >= WR_BASE) && (cmd_q <= WR_LAST);
  wire do_clear = last_bit && (cmd_q == 8'hB1) && val_nx[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= 8'h00;
      cmd_q   <= 8'h00;
      val_q   <= 8'h00;
      phase_q <= 5'd0;
    end else if (abort) begin
      ctl_q   <= ctl_wdata;
      cmd_q   <= 8'h00;
      val_q   <= 8'h00;
      phase_q <= 5'd0;
    end else if (ctl_we) begin
      ctl_q <= drive ? {ctl_wdata[7:3], reply_byte[bit_idx], ctl_wdata[1:0]} : ctl_wdata;
      if (in_cmd) cmd_q <= {cmd_q[6:0], ctl_wdata[2]};
      if (in_val) val_q <= val_nx;
      if (fall && phase_q != 5'd16) phase_q <= phase_q + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= 8'h00;
      status_q <= STATUS_INIT;
      irq_q    <= 1'b0;
    end else begin
      if (do_wr) ram[cmd_q[AW-1:0] - WR_BASE[AW-1:0]] <= val_nx;
      if (do_clear) status_q <= status_q & ~8'h18;
      irq_q <= do_clear;
    end
  end

  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] bottom);
    if (v == top) return bottom;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  wire c_sec = sec_tick;
  wire c_min = c_sec && (sec_q == 8'h59);
  wire c_hr  = c_min && (min_q == 8'h59);
  wire c_day = c_hr  && (hr_q  == 8'h23);
  wire c_mon = c_day && (day_q == 8'h31);
  wire c_yr  = c_mon && (mon_q == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00;
      day_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00;
    end else begin
      if (c_sec) sec_q <= bcd_step(sec_q, 8'h59, 8'h00);
      if (c_min) min_q <= bcd_step(min_q, 8'h59, 8'h00);
      if (c_hr)  hr_q  <= bcd_step(hr_q,  8'h23, 8'h00);
      if (c_day) day_q <= bcd_step(day_q, 8'h31, 8'h01);
      if (c_mon) mon_q <= bcd_step(mon_q, 8'h12, 8'h01);
      if (c_yr)  yr_q  <= bcd_step(yr_q,  8'h99, 8'h00);
    end
  end

  assign ctl_rdata = ctl_q;
  assign irq_clr   = irq_q;
endmodule

// File: rtl/serial_rtc_chk.sv
module serial_rtc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       irq_clr,
  input logic [4:0] phase,
  input logic [7:0] cmd,
  input logic [7:0] status,
  input logic [7:0] sec
);
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 5'd16); // R3
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(phase)); // R3
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[0]) |=> (phase == 5'd0 && cmd == 8'h00)); // R9
  AST_CTL_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[7:3] == $past(ctl_wdata[7:3]) &&
                ctl_rdata[1:0] == $past(ctl_wdata[1:0]))); // R2
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> $past(ctl_we)); // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq_clr); // R8
  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> (status[4:3] == 2'b00)); // R8
  AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[3:0] <= 4'd9) && (sec[7:4] <= 4'd5)); // R10
endmodule

bind serial_rtc serial_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .irq_clr(irq_clr), .phase(phase_q), .cmd(cmd_q),
  .status(status_q), .sec(sec_q)
);

// File: tb/sim_serial_rtc.sv
module sim_serial_rtc;
  logic clk = 1'b0, rst_n = 1'b0, ctl_we = 1'b0, sec_tick = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic irq_clr;
  int nchk = 0, nfail = 0, irq_cnt = 0, ticks = 0;
  localparam logic [7:0] UP = 8'hA8;

  always #2 clk = ~clk;

  serial_rtc u0 (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
                 .ctl_rdata(ctl_rdata), .sec_tick(sec_tick), .irq_clr(irq_clr));

  always @(negedge clk) if (irq_clr) irq_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [7:0] b);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = b;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] v, input bit noise,
                      output logic [7:0] got);
    got = 8'h00;
    cpu_wr(UP | 8'h03);
    for (int i = 0; i < 16; i++) begin
      logic d;
      d = (i < 8) ? c[7-i] : v[15-i];
      cpu_wr(UP | {5'b0, d, 2'b11});
      cpu_wr(UP | {5'b0, d, 2'b01});
      if (i >= 8) got = {got[6:0], ctl_rdata[2]};
      if (noise) cpu_wr(UP | {5'b0, ~d, 2'b01});
    end
    cpu_wr(UP);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
    end
    @(negedge clk); sec_tick = 1'b0;
    ticks += n;
  endtask

  function automatic logic [7:0] bcd(input int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic check_time();
    logic [7:0] g;
    int days;
    days = ticks / 86400;
    xfer(8'h20, 8'h00, 0, g); check("R7 seconds", g, bcd(ticks % 60));
    xfer(8'h21, 8'h00, 0, g); check("R7 minutes", g, bcd((ticks / 60) % 60));
    xfer(8'h22, 8'h00, 0, g); check("R7 hours", g, bcd((ticks / 3600) % 24));
    xfer(8'h24, 8'h00, 0, g); check("R7 day", g, bcd(days % 31 + 1));
    xfer(8'h25, 8'h00, 0, g); check("R7 month", g, bcd((days / 31) % 12 + 1));
    xfer(8'h26, 8'h00, 0, g); check("R7 year", g, bcd(days / 372));
    foreach (empty_codes[k]) begin
      xfer(empty_codes[k], 8'h00, 0, g); check("R7 unused time code", g, 8'h00);
    end
  endtask

  logic [7:0] empty_codes [10] = '{8'h23, 8'h27, 8'h28, 8'h29, 8'h2A,
                                   8'h2B, 8'h2C, 8'h2D, 8'h2E, 8'h2F};

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] g;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata reset", ctl_rdata, 8'h00);
    check("R1 irq_clr reset", irq_clr, 1'b0);
    xfer(8'h30, 8'h00, 0, g); check("R1 R6 status reset", g, 8'h90);
    xfer(8'h31, 8'h00, 0, g); check("R6 control byte", g, 8'h00);
    xfer(8'h05, 8'h00, 0, g); check("R1 ram reset", g, 8'h00);
    check("R2 readback after end", ctl_rdata, UP);
    cpu_wr(8'hFA); check("R2 raw write readback", ctl_rdata, 8'hFA);
    check_time();

    for (int a = 0; a < 32; a++) xfer(8'h80 + 8'(a), pat(a), 0, g);
    for (int a = 0; a < 32; a++) begin
      xfer(8'(a), 8'h00, 0, g); check("R4 R5 ram sweep", g, pat(a));
    end

    xfer(8'h83, 8'h5C, 1, g);
    xfer(8'h03, 8'h00, 1, g); check("R3 extra non-edge writes ignored", g, 8'h5C);

    cpu_wr(UP | 8'h03);
    for (int i = 0; i < 10; i++) begin
      logic d;
      d = (i < 8) ? 1'(8'h87 >> (7 - i)) : 1'b1;
      cpu_wr(UP | {5'b0, d, 2'b11});
      cpu_wr(UP | {5'b0, d, 2'b01});
    end
    cpu_wr(UP);
    xfer(8'h07, 8'h00, 0, g); check("R9 aborted write leaves ram", g, pat(7));
    xfer(8'h30, 8'h00, 0, g); check("R9 abort then fresh command", g, 8'h90);

    xfer(8'h40, 8'hC3, 0, g); check("R11 non-read command passthrough", g, 8'hC3);
    xfer(8'hA0, 8'h3C, 0, g); check("R11 unmapped write passthrough", g, 8'h3C);

    n0 = irq_cnt;
    xfer(8'hB1, 8'hFB, 0, g);
    check("R8 no clear without bit2 irq", irq_cnt - n0, 0);
    xfer(8'h30, 8'h00, 0, g); check("R8 status kept", g, 8'h90);
    n0 = irq_cnt;
    xfer(8'hB1, 8'h04, 0, g);
    check("R8 irq_clr single pulse", irq_cnt - n0, 1);
    xfer(8'h30, 8'h00, 0, g); check("R8 status cleared", g, 8'h80);

    tick(3725);
    check_time();
    tick(86400);
    check_time();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule